// File: doc/BRIEF.md
# Parallel printer port register block

This block connects a 16-bit processor bus to a parallel printer cable. Writing the data register places the low byte of the bus word on the eight printer data lines. The same write then fires an active-low strobe pulse of fixed length, so software never has to toggle the strobe itself. A control register keeps the upper byte of the word it is written with, and that byte drives the printer control lines. A status read returns the paper-out, select/error and battery-fault signals in the upper byte. The lower byte of the status read is a fixed open-bus pattern.

Two outputs go to the input port of a UART. The first is a level that flips on every rising edge of the active-low acknowledge line, which lets the UART raise a change-detect interrupt. The second is an inverted copy of BUSY. Both printer inputs are synchronized to the bus clock before use.

Top module: `pp_port`

## Requirements
- R1: While `rst_ni` is low and after it is released, `pdata_o` and `ctrl_o` are 0x00, `strobe_no` is 1, `ack_tog_o` is 0, and `busy_n_o` is 1 while BUSY is low.
- R2: A write (`sel_i`=1, `wr_i`=1) to address 0 loads `wdata_i[7:0]` into `pdata_o` at that clock edge. `wdata_i[15:8]` has no effect on `pdata_o`.
- R3: After a data write, `strobe_no` goes low one clock edge after `pdata_o` updates. It stays low for exactly `PULSE_CYC` cycles (8 by default) and then returns high.
- R4: A data write made while a strobe pulse is active restarts the pulse. `strobe_no` then stays low for a full `PULSE_CYC` cycles, counted from the edge after the new write.
- R5: A write to address 1 loads `wdata_i[15:8]` into `ctrl_o`. `ctrl_o[0]` enables the first printer control line and `ctrl_o[1]` enables the second.
- R6: A write to address 1 ignores `wdata_i[7:0]` and leaves `pdata_o` unchanged. A write to address 0 leaves `ctrl_o` unchanged. Writes to addresses 2 and 3 change neither register and fire no strobe.
- R7: A read (`sel_i`=1, `wr_i`=0) of address 1 returns `batt_bad_i` in bit 15, `sel_err_i` in bit 9 and `paper_out_i` in bit 8. Bits 14..10 read 0 and bits 7..0 read 0x80.
- R8: Any other bus state, including a read of address 0, 2 or 3, returns 0x0080 on `rdata_o`.
- R9: Each low-to-high transition of `ack_ni` flips `ack_tog_o` on the third clock edge after the change. A high-to-low transition leaves `ack_tog_o` unchanged.
- R10: `busy_n_o` equals the inverse of `busy_i`, delayed by two clock edges.
- R11: A write with `sel_i`=0 changes no register and fires no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Block select for the current bus cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address: 0 data, 1 control/status |
| wdata_i | input | 16 | Write data word |
| rdata_o | output | 16 | Read data word |
| pdata_o | output | 8 | Printer data lines |
| strobe_no | output | 1 | Data strobe to printer, active low |
| ctrl_o | output | 8 | Printer control line enables |
| ack_ni | input | 1 | Printer acknowledge, active low, asynchronous |
| busy_i | input | 1 | Printer busy, asynchronous |
| paper_out_i | input | 1 | Paper-out status |
| sel_err_i | input | 1 | Not-selected-or-error status |
| batt_bad_i | input | 1 | Battery fault status |
| ack_tog_o | output | 1 | Level flipped on each acknowledge release |
| busy_n_o | output | 1 | Synchronized, inverted BUSY |

## Verification
The write and read patterns use different values in the upper and lower bytes. This exposes any swap of byte lanes or any leak of the ignored byte into `pdata_o` or `ctrl_o`. Status reads set one input at a time and then all three together. These patterns separate the bit positions 8, 9 and 15 from one another and from the fixed open-bus byte. Reads of the non-status addresses confirm that the fixed pattern does not depend on the inputs. The strobe is measured cycle by cycle, both for a single write and for a write made partway through a pulse. Acknowledge is driven through both edge directions, so the toggle responds only to the release of the line and with the stated latency.

// File: rtl/pp_port_pkg.sv
package pp_port_pkg;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned BUS_W    = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ZERO_W   = BUS_W - BYTE_W - 3;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;

  localparam logic [BYTE_W-1:0] OPEN_BUS = 8'h80;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pp_strobe_gen.sv
module pp_strobe_gen #(
  parameter int unsigned PULSE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic strobe_no
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic          fire_q;
  logic [CW-1:0] cnt_q;

  // one-cycle delay so data lines settle before strobe falls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fire_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      fire_q <= fire_i;
      if (fire_q)             cnt_q <= LOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
    end
  end

  assign strobe_no = (cnt_q == '0);

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> (cnt_q == LOAD));
  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  p_retrigger_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_q && cnt_q != '0) |=> !strobe_no);
  p_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);
endmodule

// File: rtl/pp_edge_toggle.sv
module pp_edge_toggle #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic toggle_o
);
  logic prev_q, tog_q, rise;

  assign rise = level_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= RST_VAL;
      tog_q  <= 1'b0;
    end else begin
      prev_q <= level_i;
      if (rise) tog_q <= ~tog_q;
    end
  end

  assign toggle_o = tog_q;

  p_flip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> (toggle_o != $past(toggle_o)));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(toggle_o));
endmodule

// File: rtl/pp_port.sv
module pp_port
  import pp_port_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [BYTE_W-1:0] pdata_o,
  output logic              strobe_no,
  output logic [BYTE_W-1:0] ctrl_o,
  input  logic              ack_ni,
  input  logic              busy_i,
  input  logic              paper_out_i,
  input  logic              sel_err_i,
  input  logic              batt_bad_i,
  output logic              ack_tog_o,
  output logic              busy_n_o
);
  logic we_data, we_ctrl, rd_stat;
  logic [BYTE_W-1:0] pdata_q, ctrl_q;
  logic ack_s, busy_s;

  assign we_data = sel_i & wr_i  & (addr_i == ADDR_DATA);
  assign we_ctrl = sel_i & wr_i  & (addr_i == ADDR_CTRL);
  assign rd_stat = sel_i & ~wr_i & (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdata_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (we_data) pdata_q <= wdata_i[BYTE_W-1:0];
      if (we_ctrl) ctrl_q  <= wdata_i[BUS_W-1:BYTE_W];
    end
  end

  assign pdata_o = pdata_q;
  assign ctrl_o  = ctrl_q;

  always_comb begin
    if (rd_stat)
      rdata_o = {batt_bad_i, {ZERO_W{1'b0}}, sel_err_i, paper_out_i, OPEN_BUS};
    else
      rdata_o = {{BYTE_W{1'b0}}, OPEN_BUS};
  end

  pp_strobe_gen #(.PULSE_CYC(PULSE_CYC)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (we_data),
    .strobe_no(strobe_no)
  );

  // ack idles high: reset to 1 so release of reset makes no edge
  pp_sync #(.W(1), .RST_VAL(1'b1)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_ni),
    .q_o   (ack_s)
  );

  pp_sync #(.W(1), .RST_VAL(1'b0)) u_busy_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (busy_i),
    .q_o   (busy_s)
  );

  assign busy_n_o = ~busy_s;

  pp_edge_toggle #(.RST_VAL(1'b1)) u_ack_tog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (ack_s),
    .toggle_o(ack_tog_o)
  );

  p_data_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_data |=> (pdata_o == $past(wdata_i[BYTE_W-1:0])));
  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_data |=> $stable(pdata_o));
  p_ctrl_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_ctrl |=> (ctrl_o == $past(wdata_i[BUS_W-1:BYTE_W])));
  p_ctrl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ctrl |=> $stable(ctrl_o));
  p_strobe_after_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_data |=> ##1 !strobe_no);
endmodule

// File: tb/pp_port_tb.sv
module pp_port_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  pdata, ctrl;
  logic        strobe_n, ack_tog, busy_n;
  logic        ack_n = 1'b1, busy = 1'b0;
  logic        paper = 1'b0, sel_err = 1'b0, batt = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pp_port #(.PULSE_CYC(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pdata_o(pdata), .strobe_no(strobe_n),
    .ctrl_o(ctrl), .ack_ni(ack_n), .busy_i(busy), .paper_out_i(paper),
    .sel_err_i(sel_err), .batt_bad_i(batt), .ack_tog_o(ack_tog),
    .busy_n_o(busy_n)
  );

  typedef struct packed {
    logic        is_wr;
    logic [1:0]  a;
    logic [15:0] wd;
    logic [2:0]  stat;   // {batt, sel_err, paper}
    logic [7:0]  exp_pd;
    logic [7:0]  exp_ctrl;
    logic [15:0] exp_rd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 16'hA55A, 3'b000, 8'h5A, 8'h00, 16'h0080},  // R2
    '{1'b1, 2'd1, 16'h03FF, 3'b000, 8'h5A, 8'h03, 16'h0080},  // R5 R6
    '{1'b1, 2'd2, 16'h1234, 3'b000, 8'h5A, 8'h03, 16'h0080},  // R6
    '{1'b1, 2'd0, 16'hFF00, 3'b000, 8'h00, 8'h03, 16'h0080},  // R2 R6
    '{1'b0, 2'd1, 16'h0000, 3'b000, 8'h00, 8'h03, 16'h0080},  // R7
    '{1'b0, 2'd1, 16'h0000, 3'b001, 8'h00, 8'h03, 16'h0180},  // R7
    '{1'b0, 2'd1, 16'h0000, 3'b010, 8'h00, 8'h03, 16'h0280},  // R7
    '{1'b0, 2'd1, 16'h0000, 3'b100, 8'h00, 8'h03, 16'h8080},  // R7
    '{1'b0, 2'd1, 16'h0000, 3'b111, 8'h00, 8'h03, 16'h8380},  // R7
    '{1'b0, 2'd0, 16'h0000, 3'b111, 8'h00, 8'h03, 16'h0080},  // R8
    '{1'b0, 2'd3, 16'h0000, 3'b111, 8'h00, 8'h03, 16'h0080},  // R8
    '{1'b1, 2'd1, 16'hC300, 3'b000, 8'h00, 8'hC3, 16'h0080}   // R5
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at next negedge after the write edge
  task automatic bus_write(input logic s, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    sel = s; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 pdata", {8'h00, pdata}, 16'h0000);
    check("R1 ctrl", {8'h00, ctrl}, 16'h0000);
    check("R1 strobe", {15'h0, strobe_n}, 16'h0001);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ack_tog after release", {15'h0, ack_tog}, 16'h0000);
    check("R1 busy_n", {15'h0, busy_n}, 16'h0001);
    check("R1 strobe after release", {15'h0, strobe_n}, 16'h0001);

    // table walk
    for (int i = 0; i < NV; i++) begin
      {batt, sel_err, paper} = VEC[i].stat;
      if (VEC[i].is_wr) begin
        bus_write(1'b1, VEC[i].a, VEC[i].wd);
        repeat (10) @(negedge clk);
      end else begin
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = VEC[i].a;
        #2;
        check($sformatf("R7/R8 read vec %0d", i), rdata, VEC[i].exp_rd);
        @(negedge clk);
        sel = 1'b0; addr = '0;
      end
      check($sformatf("R2/R6 pdata vec %0d", i), {8'h00, pdata}, {8'h00, VEC[i].exp_pd});
      check($sformatf("R5/R6 ctrl vec %0d", i), {8'h00, ctrl}, {8'h00, VEC[i].exp_ctrl});
    end
    {batt, sel_err, paper} = 3'b000;
    #2;
    check("R8 idle rdata", rdata, 16'h0080);

    // R3 exact strobe timing
    bus_write(1'b1, 2'd0, 16'h0011);
    check("R3 strobe high at data update", {15'h0, strobe_n}, 16'h0001);
    check("R2 pdata 11", {8'h00, pdata}, 16'h0011);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      check($sformatf("R3 strobe low cycle %0d", c), {15'h0, strobe_n}, 16'h0000);
    end
    @(negedge clk);
    check("R3 strobe released", {15'h0, strobe_n}, 16'h0001);
    repeat (3) @(negedge clk);

    // R4 retrigger
    bus_write(1'b1, 2'd0, 16'h0022);
    repeat (2) @(negedge clk);
    bus_write(1'b1, 2'd0, 16'h0033);
    check("R4 low at rewrite", {15'h0, strobe_n}, 16'h0000);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      check($sformatf("R4 strobe low cycle %0d", c), {15'h0, strobe_n}, 16'h0000);
    end
    @(negedge clk);
    check("R4 strobe released", {15'h0, strobe_n}, 16'h0001);
    check("R2 pdata 33", {8'h00, pdata}, 16'h0033);

    // R11 write without select
    bus_write(1'b0, 2'd0, 16'h00EE);
    bus_write(1'b0, 2'd1, 16'hEE00);
    check("R11 strobe idle", {15'h0, strobe_n}, 16'h0001);
    @(negedge clk);
    check("R11 strobe idle later", {15'h0, strobe_n}, 16'h0001);
    check("R11 pdata", {8'h00, pdata}, 16'h0033);
    check("R11 ctrl", {8'h00, ctrl}, 16'h00C3);

    // R6 unused address fires no strobe
    bus_write(1'b1, 2'd3, 16'hFFFF);
    @(negedge clk);
    check("R6 no strobe on addr 3", {15'h0, strobe_n}, 16'h0001);

    // R9 ack: falling edge no effect, rising edge flips after 3 edges
    ack_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 no flip on fall", {15'h0, ack_tog}, 16'h0000);
    ack_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 not yet after 2 edges", {15'h0, ack_tog}, 16'h0000);
    @(negedge clk);
    check("R9 flip after 3 edges", {15'h0, ack_tog}, 16'h0001);
    ack_n = 1'b0;
    repeat (3) @(negedge clk);
    ack_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 second flip", {15'h0, ack_tog}, 16'h0000);

    // R10 busy inversion latency
    busy = 1'b1;
    @(negedge clk);
    check("R10 busy_n after 1 edge", {15'h0, busy_n}, 16'h0001);
    @(negedge clk);
    check("R10 busy_n after 2 edges", {15'h0, busy_n}, 16'h0000);
    busy = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 busy_n released", {15'h0, busy_n}, 16'h0001);

    // R1 reset mid-activity
    bus_write(1'b1, 2'd0, 16'h0077);
    @(negedge clk);
    rst_ni = 1'b0;
    #2;
    check("R1 strobe in reset", {15'h0, strobe_n}, 16'h0001);
    check("R1 pdata in reset", {8'h00, pdata}, 16'h0000);
    check("R1 ctrl in reset", {8'h00, ctrl}, 16'h0000);

    finish_run();
  end
endmodule